// File: doc/BRIEF.md
# Double-Buffered TDM Channel FIFO with Receive-Full Arbiter

This block sits between a time-division-multiplexed serial engine and a processor. Each lane has a two-buffer transmit FIFO and a two-buffer receive FIFO, and the two buffers of each FIFO are used in turn. The processor fills transmit buffers one word at a time and the serial side drains them. The serial side fills receive buffers and the processor empties them. A buffer changes hands only as a whole: once its last word has been consumed or produced, and only on the serial-side buffer-boundary strobe.

A receive buffer that completes on any lane sets that lane's bit in a pending mask. The OR of the mask is a single receive-full request. A condition read returns the mask and clears it in the same cycle. When no transmit buffer is ready the serial side sends an idle word. Starved transmit and overfilled receive sides raise sticky flags, which the processor clears.

Top module: `tdm_pingpong_fifo`

## Requirements
- R1: After reset every buffer is empty: `cpu_tx_ready` is all ones, `cpu_rx_avail`, `cond_word`, `rx_full_irq`, `tx_underrun` and `rx_overrun` are zero, and every `ser_tx_data` lane shows `IDLE_WORD`.
- R2: Transmit words written by the processor to a lane come out of that lane's `ser_tx_data` in write order. Buffers are handed over whole, `DEPTH` words at a time. `cpu_tx_ready` is low while both buffers of the lane hold data, and a write made then is discarded.
- R3: When the serial side has consumed the last word of a transmit buffer, `ser_tx_data` shows `IDLE_WORD` and the buffer stays held until `ser_strobe`. In the cycle after the strobe, the buffer is free for the processor and the other buffer is presented to the serial side.
- R4: A `ser_tx_en` pulse while neither transmit buffer of the lane holds complete data outputs `IDLE_WORD` and sets that lane's `tx_underrun`.
- R5: Serial receive words fill a buffer in order. The buffer becomes readable (`cpu_rx_avail` high) only in the cycle after the `ser_strobe` that follows its `DEPTH`-th word. The processor reads the words in arrival order, and reading the last word releases the buffer.
- R6: A `ser_rx_en` pulse while both receive buffers of the lane hold unread data discards the word and sets that lane's `rx_overrun`.
- R7: `tx_underrun` and `rx_overrun` stay set until `cpu_flag_clr`. A new event in the same cycle as the clear leaves the flag set.
- R8: Each completed receive buffer sets bit i of `cond_word`, where i is its lane number. Completions on several lanes in the same cycle set several bits. `rx_full_irq` is high whenever any bit is set.
- R9: `cpu_cond_rd` clears every `cond_word` bit that was set before the read. A completion arriving in the same cycle as the read stays set.
- R10: `cpu_rx_rd` on a lane with no readable buffer has no effect on that lane's read order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_strobe | input | 1 | Serial buffer-boundary strobe, shared by all lanes |
| ser_tx_en | input | NUM_LANES | Serial side consumes the shown transmit word, one bit per lane |
| ser_tx_data | output | NUM_LANES x DATA_W | Transmit word per lane, `IDLE_WORD` when none is ready |
| ser_rx_en | input | NUM_LANES | Serial side delivers a receive word, one bit per lane |
| ser_rx_data | input | NUM_LANES x DATA_W | Receive word per lane |
| cpu_tx_wr | input | 1 | Processor transmit write |
| cpu_tx_lane | input | LANE_W | Lane addressed by the transmit write |
| cpu_tx_data | input | DATA_W | Transmit write data |
| cpu_tx_ready | output | NUM_LANES | Lane can accept a transmit write |
| cpu_rx_rd | input | 1 | Processor receive read (pops the shown word) |
| cpu_rx_lane | input | LANE_W | Lane addressed by the receive read |
| cpu_rx_data | output | DATA_W | Current receive word of the addressed lane |
| cpu_rx_avail | output | NUM_LANES | Lane has a readable receive buffer |
| cpu_cond_rd | input | 1 | Condition read, clears the reported bits |
| cond_word | output | NUM_LANES | Pending receive-full source mask |
| rx_full_irq | output | 1 | Combined receive-full request |
| cpu_flag_clr | input | 1 | Clears the sticky underrun and overrun flags |
| tx_underrun | output | NUM_LANES | Sticky transmit underrun per lane |
| rx_overrun | output | NUM_LANES | Sticky receive overrun per lane |

## Verification
Two kinds of collision can occur in one cycle. A receive buffer can complete on a strobe in the same cycle that the processor issues a condition read. A flag can be cleared in the same cycle that a new starve or overfill event occurs. The bench provokes the first by giving `ser_strobe` and `cpu_cond_rd` in one cycle while an older bit is already pending. It expects the older bit to clear and the new lane's bit to remain. It provokes the second by giving `ser_tx_en` on an empty lane together with `cpu_flag_clr`, and expects the underrun flag to stay set.

// File: rtl/tdm_pp_pkg.sv
package tdm_pp_pkg;
   // index width that stays legal for counts of one
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/tdm_tx_pingpong.sv
module tdm_tx_pingpong
   import tdm_pp_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DEPTH     = 4,
   parameter logic [DATA_W-1:0] IDLE_WORD = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ready,
   input  logic              strobe,
   input  logic              ser_en,
   output logic [DATA_W-1:0] ser_data,
   input  logic              flag_clr,
   output logic              underrun
);
   localparam int unsigned PW = idx_bits(DEPTH + 1);
   localparam int unsigned IW = idx_bits(DEPTH);
   localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);
   localparam logic [PW-1:0] DONE_P = PW'(DEPTH);

   logic [DATA_W-1:0] mem [2][DEPTH];
   logic [1:0]        full_q, full_d;
   logic              fill_sel_q, drain_sel_q;
   logic [PW-1:0]     fill_ptr_q, drain_ptr_q;
   logic              underrun_q;

   logic wr_ok, word_ok, drained, release_buf, starve;

   assign wr_ok       = wr_en && !full_q[fill_sel_q];
   assign word_ok     = full_q[drain_sel_q] && (drain_ptr_q != DONE_P);
   assign drained     = full_q[drain_sel_q] && (drain_ptr_q == DONE_P);
   assign release_buf = strobe && drained;
   assign starve      = ser_en && (full_q == 2'b00);

   always_comb begin
      full_d = full_q;
      if (wr_ok && fill_ptr_q == LAST_P) full_d[fill_sel_q] = 1'b1;
      if (release_buf)                   full_d[drain_sel_q] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[fill_sel_q][fill_ptr_q[IW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q      <= '0;
         fill_sel_q  <= 1'b0;
         drain_sel_q <= 1'b0;
         fill_ptr_q  <= '0;
         drain_ptr_q <= '0;
         underrun_q  <= 1'b0;
      end else begin
         full_q <= full_d;
         if (wr_ok) begin
            if (fill_ptr_q == LAST_P) begin
               fill_ptr_q <= '0;
               fill_sel_q <= ~fill_sel_q;
            end else begin
               fill_ptr_q <= fill_ptr_q + 1'b1;
            end
         end
         if (release_buf) begin
            drain_ptr_q <= '0;
            drain_sel_q <= ~drain_sel_q;
         end else if (ser_en && word_ok) begin
            drain_ptr_q <= drain_ptr_q + 1'b1;
         end
         if (starve)        underrun_q <= 1'b1;
         else if (flag_clr) underrun_q <= 1'b0;
      end
   end

   assign ready    = !full_q[fill_sel_q];
   assign ser_data = word_ok ? mem[drain_sel_q][drain_ptr_q[IW-1:0]] : IDLE_WORD;
   assign underrun = underrun_q;

   assert_full_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ready) |=> ($stable(fill_ptr_q) && $stable(fill_sel_q)));
   assert_swap_only_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(drain_sel_q));
   assert_underrun_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun_q) |-> ($past(ser_en) && $past(full_q) == 2'b00));
   assert_underrun_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(underrun_q) |-> $past(flag_clr));
endmodule

// File: rtl/tdm_rx_pingpong.sv
module tdm_rx_pingpong
   import tdm_pp_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic              ser_en,
   input  logic [DATA_W-1:0] ser_data,
   output logic              done_evt,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              avail,
   input  logic              flag_clr,
   output logic              overrun
);
   localparam int unsigned PW = idx_bits(DEPTH + 1);
   localparam int unsigned IW = idx_bits(DEPTH);
   localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);
   localparam logic [PW-1:0] DONE_P = PW'(DEPTH);

   logic [DATA_W-1:0] mem [2][DEPTH];
   logic [1:0]        full_q, full_d;
   logic              fill_sel_q, drain_sel_q;
   logic [PW-1:0]     fill_ptr_q, drain_ptr_q;
   logic              overrun_q;

   logic put_ok, complete, rd_ok, flood;

   assign put_ok   = ser_en && !full_q[fill_sel_q] && (fill_ptr_q != DONE_P);
   assign complete = strobe && !full_q[fill_sel_q] && (fill_ptr_q == DONE_P);
   assign rd_ok    = rd_en && full_q[drain_sel_q];
   assign flood    = ser_en && (full_q == 2'b11);

   always_comb begin
      full_d = full_q;
      if (complete)                        full_d[fill_sel_q]  = 1'b1;
      if (rd_ok && drain_ptr_q == LAST_P)  full_d[drain_sel_q] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (put_ok) mem[fill_sel_q][fill_ptr_q[IW-1:0]] <= ser_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q      <= '0;
         fill_sel_q  <= 1'b0;
         drain_sel_q <= 1'b0;
         fill_ptr_q  <= '0;
         drain_ptr_q <= '0;
         overrun_q   <= 1'b0;
      end else begin
         full_q <= full_d;
         if (complete) begin
            fill_ptr_q <= '0;
            fill_sel_q <= ~fill_sel_q;
         end else if (put_ok) begin
            fill_ptr_q <= fill_ptr_q + 1'b1;
         end
         if (rd_ok) begin
            if (drain_ptr_q == LAST_P) begin
               drain_ptr_q <= '0;
               drain_sel_q <= ~drain_sel_q;
            end else begin
               drain_ptr_q <= drain_ptr_q + 1'b1;
            end
         end
         if (flood)         overrun_q <= 1'b1;
         else if (flag_clr) overrun_q <= 1'b0;
      end
   end

   assign done_evt = complete;
   assign avail    = full_q[drain_sel_q];
   assign rd_data  = mem[drain_sel_q][drain_ptr_q[IW-1:0]];
   assign overrun  = overrun_q;

   assert_buf0_ready_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_q[0]) |-> $past(strobe));
   assert_buf1_ready_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_q[1]) |-> $past(strobe));
   assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_q) |-> ($past(ser_en) && $past(full_q) == 2'b11));
   assert_overrun_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(overrun_q) |-> $past(flag_clr));
   assert_empty_read_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !avail) |=> ($stable(drain_ptr_q) && $stable(drain_sel_q)));
endmodule

// File: rtl/tdm_full_arbiter.sv
module tdm_full_arbiter #(
   parameter int unsigned NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic               cond_rd,
   output logic [NUM_SRC-1:0] cond_word,
   output logic               irq
);
   logic [NUM_SRC-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (cond_rd ? '0 : pend_q) | evt;
   end

   assign cond_word = pend_q;
   assign irq       = |pend_q;

   assert_event_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));
   assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(evt) != '0));
endmodule

// File: rtl/tdm_pingpong_fifo.sv
module tdm_pingpong_fifo
   import tdm_pp_pkg::*;
#(
   parameter int unsigned NUM_LANES = 2,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DEPTH     = 4,
   parameter logic [DATA_W-1:0] IDLE_WORD = '1,
   localparam int unsigned LANE_W   = idx_bits(NUM_LANES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              ser_strobe,
   input  logic [NUM_LANES-1:0]              ser_tx_en,
   output logic [NUM_LANES-1:0][DATA_W-1:0]  ser_tx_data,
   input  logic [NUM_LANES-1:0]              ser_rx_en,
   input  logic [NUM_LANES-1:0][DATA_W-1:0]  ser_rx_data,
   input  logic                              cpu_tx_wr,
   input  logic [LANE_W-1:0]                 cpu_tx_lane,
   input  logic [DATA_W-1:0]                 cpu_tx_data,
   output logic [NUM_LANES-1:0]              cpu_tx_ready,
   input  logic                              cpu_rx_rd,
   input  logic [LANE_W-1:0]                 cpu_rx_lane,
   output logic [DATA_W-1:0]                 cpu_rx_data,
   output logic [NUM_LANES-1:0]              cpu_rx_avail,
   input  logic                              cpu_cond_rd,
   output logic [NUM_LANES-1:0]              cond_word,
   output logic                              rx_full_irq,
   input  logic                              cpu_flag_clr,
   output logic [NUM_LANES-1:0]              tx_underrun,
   output logic [NUM_LANES-1:0]              rx_overrun
);
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("NUM_LANES must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   logic [NUM_LANES-1:0]             lane_evt;
   logic [NUM_LANES-1:0][DATA_W-1:0] lane_rd_data;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic wr_hit, rd_hit;
      assign wr_hit = cpu_tx_wr && (cpu_tx_lane == LANE_W'(g));
      assign rd_hit = cpu_rx_rd && (cpu_rx_lane == LANE_W'(g));

      tdm_tx_pingpong #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDLE_WORD(IDLE_WORD)) i_tx (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_hit),
         .wr_data  (cpu_tx_data),
         .ready    (cpu_tx_ready[g]),
         .strobe   (ser_strobe),
         .ser_en   (ser_tx_en[g]),
         .ser_data (ser_tx_data[g]),
         .flag_clr (cpu_flag_clr),
         .underrun (tx_underrun[g])
      );

      tdm_rx_pingpong #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx (
         .clk      (clk),
         .rst_n    (rst_n),
         .strobe   (ser_strobe),
         .ser_en   (ser_rx_en[g]),
         .ser_data (ser_rx_data[g]),
         .done_evt (lane_evt[g]),
         .rd_en    (rd_hit),
         .rd_data  (lane_rd_data[g]),
         .avail    (cpu_rx_avail[g]),
         .flag_clr (cpu_flag_clr),
         .overrun  (rx_overrun[g])
      );
   end

   always_comb begin
      cpu_rx_data = '0;
      for (int i = 0; i < NUM_LANES; i++) begin
         if (cpu_rx_lane == LANE_W'(i)) cpu_rx_data = lane_rd_data[i];
      end
   end

   tdm_full_arbiter #(.NUM_SRC(NUM_LANES)) i_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (lane_evt),
      .cond_rd   (cpu_cond_rd),
      .cond_word (cond_word),
      .irq       (rx_full_irq)
   );
endmodule

// File: tb/test_tdm_pingpong_fifo.sv
module test_tdm_pingpong_fifo;
   localparam int L = 2;
   localparam int W = 8;
   localparam int D = 4;
   localparam logic [W-1:0] IDLE = 8'hFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_strobe = 1'b0;
   logic [L-1:0] ser_tx_en = '0;
   logic [L-1:0][W-1:0] ser_tx_data;
   logic [L-1:0] ser_rx_en = '0;
   logic [L-1:0][W-1:0] ser_rx_data = '0;
   logic cpu_tx_wr = 1'b0;
   logic [0:0] cpu_tx_lane = '0;
   logic [W-1:0] cpu_tx_data = '0;
   logic [L-1:0] cpu_tx_ready;
   logic cpu_rx_rd = 1'b0;
   logic [0:0] cpu_rx_lane = '0;
   logic [W-1:0] cpu_rx_data;
   logic [L-1:0] cpu_rx_avail;
   logic cpu_cond_rd = 1'b0;
   logic [L-1:0] cond_word;
   logic rx_full_irq;
   logic cpu_flag_clr = 1'b0;
   logic [L-1:0] tx_underrun;
   logic [L-1:0] rx_overrun;

   int n_checks = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   tdm_pingpong_fifo #(.NUM_LANES(L), .DATA_W(W), .DEPTH(D), .IDLE_WORD(IDLE)) i_tdm_pingpong_fifo (
      .clk(clk), .rst_n(rst_n), .ser_strobe(ser_strobe),
      .ser_tx_en(ser_tx_en), .ser_tx_data(ser_tx_data),
      .ser_rx_en(ser_rx_en), .ser_rx_data(ser_rx_data),
      .cpu_tx_wr(cpu_tx_wr), .cpu_tx_lane(cpu_tx_lane), .cpu_tx_data(cpu_tx_data),
      .cpu_tx_ready(cpu_tx_ready), .cpu_rx_rd(cpu_rx_rd), .cpu_rx_lane(cpu_rx_lane),
      .cpu_rx_data(cpu_rx_data), .cpu_rx_avail(cpu_rx_avail), .cpu_cond_rd(cpu_cond_rd),
      .cond_word(cond_word), .rx_full_irq(rx_full_irq), .cpu_flag_clr(cpu_flag_clr),
      .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
   );

   // expected serial word: the queued word when one is due, else the idle pattern
   function automatic logic [W-1:0] tx_expect(input bit due, input logic [W-1:0] word);
      return due ? word : IDLE;
   endfunction

   // expected pending mask after a cycle with old mask, read and new completions
   function automatic logic [L-1:0] cond_expect(input logic [L-1:0] old, input bit rd,
                                                input logic [L-1:0] evt);
      return (rd ? '0 : old) | evt;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cpu_write(input int lane, input logic [W-1:0] d);
      cpu_tx_wr = 1'b1; cpu_tx_lane = 1'(lane); cpu_tx_data = d;
      step();
      cpu_tx_wr = 1'b0;
   endtask

   task automatic strobe();
      ser_strobe = 1'b1;
      step();
      ser_strobe = 1'b0;
   endtask

   task automatic drain_check(input int lane, input bit due, input logic [W-1:0] w, input string req);
      chk(req, ser_tx_data[lane], tx_expect(due, w));
      ser_tx_en[lane] = 1'b1;
      step();
      ser_tx_en[lane] = 1'b0;
   endtask

   task automatic rx_word(input int lane, input logic [W-1:0] d);
      ser_rx_en[lane] = 1'b1; ser_rx_data[lane] = d;
      step();
      ser_rx_en[lane] = 1'b0;
   endtask

   task automatic read_check(input int lane, input logic [W-1:0] exp, input string req);
      cpu_rx_lane = 1'(lane);
      #1;
      chk(req, cpu_rx_data, exp);
      cpu_rx_rd = 1'b1;
      step();
      cpu_rx_rd = 1'b0;
   endtask

   task automatic cond_read();
      cpu_cond_rd = 1'b1;
      step();
      cpu_cond_rd = 1'b0;
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin : main
      logic [W-1:0] bufa [D];
      logic [W-1:0] bufb [D];
      logic [L-1:0] expc;
      int unsigned seed_val;
      seed_val = $urandom(32'd2024);

      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      chk("R1 tx_ready", cpu_tx_ready, 2'b11);
      chk("R1 rx_avail", cpu_rx_avail, 2'b00);
      chk("R1 cond_word", cond_word, 2'b00);
      chk("R1 irq", rx_full_irq, 1'b0);
      chk("R1 flags", {tx_underrun, rx_overrun}, 4'b0);
      chk("R1 idle lane0", ser_tx_data[0], IDLE);
      chk("R1 idle lane1", ser_tx_data[1], IDLE);

      // R2: fill both transmit buffers of lane 0, then an extra write is dropped
      for (int k = 0; k < D; k++) begin bufa[k] = W'($urandom); cpu_write(0, bufa[k]); end
      chk("R2 ready after one buffer", cpu_tx_ready[0], 1'b1);
      for (int k = 0; k < D; k++) begin bufb[k] = W'($urandom); cpu_write(0, bufb[k]); end
      chk("R2 ready low when both full", cpu_tx_ready[0], 1'b0);
      cpu_write(0, 8'h5A);
      for (int k = 0; k < D; k++) drain_check(0, 1'b1, bufa[k], "R2 first buffer order");
      // R3: consumed buffer is held until the strobe
      chk("R3 idle while awaiting strobe", ser_tx_data[0], IDLE);
      chk("R3 not released before strobe", cpu_tx_ready[0], 1'b0);
      drain_check(0, 1'b0, 8'h00, "R3 extra consume still idle");
      chk("R3 no underrun while buffer held", tx_underrun[0], 1'b0);
      strobe();
      chk("R3 released after strobe", cpu_tx_ready[0], 1'b1);
      for (int k = 0; k < D; k++) drain_check(0, 1'b1, bufb[k], "R2 second buffer order, dropped write absent");
      strobe();

      // R4 underrun and R7 sticky clear
      drain_check(0, 1'b0, 8'h00, "R4 idle on empty");
      chk("R4 underrun set", tx_underrun[0], 1'b1);
      chk("R4 other lane untouched", tx_underrun[1], 1'b0);
      step();
      chk("R7 underrun sticky", tx_underrun[0], 1'b1);
      cpu_flag_clr = 1'b1; step(); cpu_flag_clr = 1'b0;
      chk("R7 underrun cleared", tx_underrun[0], 1'b0);
      cpu_flag_clr = 1'b1; ser_tx_en[0] = 1'b1; step();
      cpu_flag_clr = 1'b0; ser_tx_en[0] = 1'b0;
      chk("R7 set wins over clear", tx_underrun[0], 1'b1);
      cpu_flag_clr = 1'b1; step(); cpu_flag_clr = 1'b0;

      // R10: read on an empty lane, then R5 receive path on lane 1
      cpu_rx_lane = 1'b1; cpu_rx_rd = 1'b1; step(); cpu_rx_rd = 1'b0;
      for (int k = 0; k < D; k++) begin bufa[k] = W'($urandom); rx_word(1, bufa[k]); end
      chk("R5 not readable before strobe", cpu_rx_avail[1], 1'b0);
      chk("R8 no source before strobe", cond_word, 2'b00);
      strobe();
      chk("R5 readable after strobe", cpu_rx_avail[1], 1'b1);
      chk("R8 lane1 source bit", cond_word, 2'b10);
      chk("R8 irq raised", rx_full_irq, 1'b1);
      read_check(1, bufa[0], "R10 empty read ignored, first word first");
      for (int k = 1; k < D; k++) read_check(1, bufa[k], "R5 read order");
      chk("R5 released after last read", cpu_rx_avail[1], 1'b0);
      cond_read();
      chk("R9 cleared by read", cond_word, 2'b00);
      chk("R9 irq dropped", rx_full_irq, 1'b0);

      // R6 overrun on lane 0
      for (int k = 0; k < D; k++) begin bufa[k] = W'($urandom); rx_word(0, bufa[k]); end
      strobe();
      for (int k = 0; k < D; k++) begin bufb[k] = W'($urandom); rx_word(0, bufb[k]); end
      strobe();
      chk("R6 no overrun yet", rx_overrun[0], 1'b0);
      rx_word(0, 8'h77);
      chk("R6 overrun set", rx_overrun[0], 1'b1);
      chk("R8 lane0 source bit", cond_word, 2'b01);

      // R9: completion on lane 1 in the same cycle as the condition read
      for (int k = 0; k < D; k++) rx_word(1, 8'h10 + 8'(k));
      expc = cond_expect(cond_word, 1'b1, 2'b10);
      ser_strobe = 1'b1; cpu_cond_rd = 1'b1; step();
      ser_strobe = 1'b0; cpu_cond_rd = 1'b0;
      chk("R9 same-cycle event stays pending", cond_word, expc);
      cond_read();
      for (int k = 0; k < D; k++) read_check(1, 8'h10 + 8'(k), "R5 lane1 order");
      for (int k = 0; k < D; k++) read_check(0, bufa[k], "R6 first buffer intact");
      for (int k = 0; k < D; k++) read_check(0, bufb[k], "R6 dropped word absent");
      chk("R7 overrun sticky", rx_overrun[0], 1'b1);
      cpu_flag_clr = 1'b1; step(); cpu_flag_clr = 1'b0;
      chk("R7 overrun cleared", rx_overrun[0], 1'b0);

      // R8: both lanes complete on one strobe
      for (int k = 0; k < D; k++) begin
         ser_rx_en = 2'b11;
         ser_rx_data[0] = 8'h20 + 8'(k);
         ser_rx_data[1] = 8'h30 + 8'(k);
         step();
      end
      ser_rx_en = '0;
      strobe();
      chk("R8 two sources merged", cond_word, 2'b11);
      chk("R8 single irq", rx_full_irq, 1'b1);
      cond_read();
      for (int k = 0; k < D; k++) read_check(0, 8'h20 + 8'(k), "R8 lane0 data");
      for (int k = 0; k < D; k++) read_check(1, 8'h30 + 8'(k), "R8 lane1 data");

      // random rounds on both paths
      for (int it = 0; it < 24; it++) begin
         int ln;
         ln = int'($urandom % 2);
         for (int k = 0; k < D; k++) begin bufa[k] = W'($urandom); cpu_write(ln, bufa[k]); end
         for (int k = 0; k < D; k++) drain_check(ln, 1'b1, bufa[k], "R2 random transmit");
         strobe();
         for (int k = 0; k < D; k++) begin bufb[k] = W'($urandom); rx_word(ln, bufb[k]); end
         strobe();
         chk("R8 random source", cond_word, cond_expect(2'b00, 1'b0, 2'(1 << ln)));
         cond_read();
         for (int k = 0; k < D; k++) read_check(ln, bufb[k], "R5 random receive");
      end
      chk("R4 no spurious underrun", tx_underrun, 2'b00);
      chk("R6 no spurious overrun", rx_overrun, 2'b00);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule